// File: doc/BRIEF.md
# Preset-Loadable 24-Bit Position Counter

This block is one position-counting channel driven by a byte-wide host port with two addresses: a data port and a control/status port. A separate front end supplies already-decoded count-up and count-down strobes, an index level and a noise-error strobe. The channel keeps a 24-bit counter, a 24-bit preset register and a 24-bit output latch. All multi-byte values move through one internal byte pointer, least significant byte first. The counter cannot be written directly. The host fills the preset and then commands a transfer, or it zeroes the counter.

Control-port writes carry a 3-bit register select in bits 7:5. The select reaches a command decoder (resets and transfers), a count-mode register, an I/O control register (count enable, index-load enable, event select) and an index control register (index polarity). Four count modes set what happens at the ends of the range. Plain wrap, clamp at the preset or zero, freeze after a wrap, and modulo-preset are available. The preset serves as the ceiling in the clamp and modulo modes. Carry, borrow and compare events toggle status flags, and one selected event drives a one-cycle `event_out` pulse for interrupt logic.

Top module: `poscnt24`

## Requirements
- R1: After synchronous reset the counter, preset, output latch, byte pointer, prescaler output and all status flags are zero, `event_out` is low, counting is disabled, index loading is disabled, event select is carry, and mode is normal.
- R2: A control write decodes bits 7:5: 000 command, 001 count mode (mode in bits 2:1), 010 I/O control (bit 0 count enable, bit 1 index-load disable, bits 4:3 event select), 011 index control (bit 1 inverts the index level). Selects 100 to 111 change nothing.
- R3: Each data-port write stores a byte into the preset and each data-port read returns a byte of the output latch. Both use one shared pointer that starts at byte 0 (LSB), steps once per access and wraps from byte 2 to byte 0. Command bit 0 returns the pointer to byte 0.
- R4: Command bits 2:1 choose a reset: 01 zeroes the counter, 10 clears borrow, carry, compare and sign, 11 clears the error flag.
- R5: Command bits 4:3 choose a transfer: 01 preset to counter, 10 counter to output latch, 11 preset low byte to `prescale_out`. Data writes never change the counter.
- R6: A status read returns borrow toggle in bit 0, carry toggle in bit 1, compare toggle in bit 2, sign in bit 3, error in bit 4 and last direction in bit 5 (1 = up), with bits 7:6 zero. Sign is set by a borrow and cleared by a carry.
- R7: Each cycle with `step_up` or `step_dn` high moves the counter by one, and only while count enable is set. Otherwise the counter holds.
- R8: In normal mode (0) counting up from 0xFFFFFF gives 0 and toggles carry, and counting down from 0 gives 0xFFFFFF and toggles borrow. Borrow XOR carry then acts as a 25th count bit.
- R9: In range-limit mode (1) an up step at or above the preset and a down step at zero leave the counter unchanged and toggle carry or borrow respectively.
- R10: In non-recycle mode (2) the counter wraps as in normal mode and then ignores steps until it is zeroed or loaded from the preset.
- R11: In modulo mode (3) an up step at or above the preset gives 0 with a carry, and a down step at 0 gives the preset with a borrow.
- R12: The compare toggle flips when a step moves the counter onto the preset value. `event_out` pulses for one cycle, registered on the same edge as the counter update, for the event picked by select 00 carry, 01 compare, 10 carry or borrow, 11 index edge.
- R13: An index edge is a rise of the index level after optional inversion. When index loading is enabled (I/O control bit 1 = 0), the edge copies the preset into the counter.
- R14: The error flag is set by `noise_err` and stays set until a clear-error command. A flag-clear command does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one byte per cycle |
| bus_rd | input | 1 | Host read strobe, one byte per cycle |
| bus_ctl | input | 1 | Address: 1 control/status port, 0 data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Status byte or output-latch byte at the pointer |
| step_up | input | 1 | Count-up strobe from the front end |
| step_dn | input | 1 | Count-down strobe from the front end |
| index_in | input | 1 | Index level from the front end |
| noise_err | input | 1 | Noise-error strobe from the front end |
| event_out | output | 1 | One-cycle pulse on the selected event |
| prescale_out | output | 8 | Filter prescaler value for the front end |

## Verification
The assertions assume the host never strobes a read and a write in the same cycle. They also assume the front end never raises both step strobes together, because the counter gives the up strobe priority and the wrap and hold checks depend on one direction per cycle. The bench drives every strobe from negative-edge tasks that raise a single signal at a time, and it never overlaps host accesses with each other. It places wrap and clamp boundaries one or two steps away from the loaded value, so each end-of-range rule is hit on a known cycle.

// File: rtl/poscnt_pkg.sv
package poscnt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_MODE   = 3'd1;
    localparam logic [2:0] SEL_IOCTL  = 3'd2;
    localparam logic [2:0] SEL_IDXCTL = 3'd3;

    typedef enum logic [1:0] {
        CM_NORMAL    = 2'd0,
        CM_RANGE     = 2'd1,
        CM_NORECYCLE = 2'd2,
        CM_MODULO    = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        EV_CARRY   = 2'd0,
        EV_COMPARE = 2'd1,
        EV_WRAP    = 2'd2,
        EV_INDEX   = 2'd3
    } ev_sel_e;

    typedef struct packed {
        ev_sel_e ev_sel;
        logic    idx_load_n;
        logic    cnt_en;
    } ioctl_t;

    typedef struct packed {
        logic rst_ptr;
        logic zero_cnt;
        logic clr_flags;
        logic clr_err;
        logic preset_to_cnt;
        logic cnt_to_latch;
        logic preset_to_psc;
    } cmd_t;

    typedef struct packed {
        logic updir;
        logic err;
        logic sign;
        logic cmp;
        logic carry;
        logic borrow;
    } flags_t;

    // Bit 0 pointer reset, bits 2:1 reset choice, bits 4:3 transfer choice.
    function automatic cmd_t decode_cmd(input logic [4:0] b);
        cmd_t c;
        c.rst_ptr       = b[0];
        c.zero_cnt      = (b[2:1] == 2'd1);
        c.clr_flags     = (b[2:1] == 2'd2);
        c.clr_err       = (b[2:1] == 2'd3);
        c.preset_to_cnt = (b[4:3] == 2'd1);
        c.cnt_to_latch  = (b[4:3] == 2'd2);
        c.preset_to_psc = (b[4:3] == 2'd3);
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input flags_t f);
        return {2'b00, f.updir, f.err, f.sign, f.cmp, f.carry, f.borrow};
    endfunction

endpackage

// File: rtl/poscnt_host.sv
module poscnt_host
    import poscnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic                  bus_ctl,
    input  logic [BYTE_W-1:0]     bus_wdata,
    input  logic [CNT_W-1:0]      count,
    input  flags_t                flags,
    output logic [BYTE_W-1:0]     bus_rdata,
    output logic [CNT_W-1:0]      preset,
    output cnt_mode_e             mode,
    output ioctl_t                ioctl,
    output logic                  idx_invert,
    output cmd_t                  cmd,
    output logic [BYTE_W-1:0]     prescale
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int PTR_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBYTES - 1);

    logic [NBYTES-1:0][BYTE_W-1:0] preset_q;
    logic [NBYTES-1:0][BYTE_W-1:0] latch_q;
    logic [PTR_W-1:0]              ptr_q;

    logic       ctl_wr, data_wr, data_rd;
    logic [2:0] sel;

    assign ctl_wr  = bus_wr &  bus_ctl;
    assign data_wr = bus_wr & ~bus_ctl;
    assign data_rd = bus_rd & ~bus_ctl;
    assign sel     = bus_wdata[7:5];

    assign cmd    = (ctl_wr && sel == SEL_CMD) ? decode_cmd(bus_wdata[4:0]) : '0;
    assign preset = preset_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q      <= '0;
            preset_q   <= '0;
            latch_q    <= '0;
            mode       <= CM_NORMAL;
            ioctl      <= '{ev_sel: EV_CARRY, idx_load_n: 1'b1, cnt_en: 1'b0};
            idx_invert <= 1'b0;
            prescale   <= '0;
        end else begin
            if (cmd.rst_ptr)
                ptr_q <= '0;
            else if (data_wr || data_rd)
                ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;

            if (data_wr)
                preset_q[ptr_q] <= bus_wdata;

            if (cmd.cnt_to_latch)
                latch_q <= count;

            if (cmd.preset_to_psc)
                prescale <= preset_q[0];

            if (ctl_wr) begin
                case (sel)
                    SEL_MODE:   mode <= cnt_mode_e'(bus_wdata[2:1]);
                    SEL_IOCTL:  ioctl <= '{ev_sel: ev_sel_e'(bus_wdata[4:3]),
                                           idx_load_n: bus_wdata[1],
                                           cnt_en: bus_wdata[0]};
                    SEL_IDXCTL: idx_invert <= bus_wdata[1];
                    default: ;
                endcase
            end
        end
    end

    assign bus_rdata = bus_ctl ? pack_status(flags) : latch_q[ptr_q];

    // R3: host never reads and writes in one cycle
    assert_one_access_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    // R3: pointer wraps to the low byte after the top byte
    assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && !bus_ctl && ptr_q == PTR_LAST) |=> (ptr_q == '0));

    // R5: latch transfer captures the counter value of the command cycle
    assert_latch_copy_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.cnt_to_latch |=> (latch_q == $past(count)));

endmodule

// File: rtl/poscnt_core.sv
module poscnt_core
    import poscnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_mode_e         mode,
    input  ioctl_t            ioctl,
    input  logic              idx_invert,
    input  logic              ld_cnt,
    input  logic              zero_cnt,
    input  logic              clr_flags,
    input  logic              clr_err,
    input  logic [CNT_W-1:0]  preset,
    input  logic              step_up,
    input  logic              step_dn,
    input  logic              index_in,
    input  logic              noise_err,
    output logic [CNT_W-1:0]  count,
    output flags_t            flags,
    output logic              event_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    flags_t           fl_q;
    logic             frozen_q, idx_act_q, ev_q;
    logic             idx_act, idx_edge, idx_load, host_load, stalled, step_ok;
    logic             carry_ev, borrow_ev, cmp_ev, ev_sel_hit;

    assign idx_act   = index_in ^ idx_invert;
    assign idx_edge  = idx_act & ~idx_act_q;
    assign idx_load  = idx_edge & ~ioctl.idx_load_n;
    assign host_load = ld_cnt | zero_cnt;
    assign stalled   = frozen_q && (mode == CM_NORECYCLE);
    assign step_ok   = ioctl.cnt_en & (step_up | step_dn) & ~stalled & ~host_load & ~idx_load;

    always_comb begin
        cnt_nxt   = cnt_q;
        carry_ev  = 1'b0;
        borrow_ev = 1'b0;
        if (step_ok && step_up) begin
            case (mode)
                CM_RANGE: begin
                    if (cnt_q >= preset) carry_ev = 1'b1;
                    else                 cnt_nxt  = cnt_q + 1'b1;
                end
                CM_MODULO: begin
                    if (cnt_q >= preset) begin cnt_nxt = '0; carry_ev = 1'b1; end
                    else                 cnt_nxt = cnt_q + 1'b1;
                end
                default: begin
                    if (cnt_q == CNT_MAX) begin cnt_nxt = '0; carry_ev = 1'b1; end
                    else                  cnt_nxt = cnt_q + 1'b1;
                end
            endcase
        end else if (step_ok && step_dn) begin
            case (mode)
                CM_RANGE: begin
                    if (cnt_q == '0) borrow_ev = 1'b1;
                    else             cnt_nxt   = cnt_q - 1'b1;
                end
                CM_MODULO: begin
                    if (cnt_q == '0) begin cnt_nxt = preset; borrow_ev = 1'b1; end
                    else             cnt_nxt = cnt_q - 1'b1;
                end
                default: begin
                    if (cnt_q == '0) begin cnt_nxt = CNT_MAX; borrow_ev = 1'b1; end
                    else             cnt_nxt = cnt_q - 1'b1;
                end
            endcase
        end
        cmp_ev = step_ok && (cnt_nxt == preset) && (cnt_nxt != cnt_q);
    end

    always_comb begin
        case (ioctl.ev_sel)
            EV_CARRY:   ev_sel_hit = carry_ev;
            EV_COMPARE: ev_sel_hit = cmp_ev;
            EV_WRAP:    ev_sel_hit = carry_ev | borrow_ev;
            default:    ev_sel_hit = idx_edge;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            fl_q      <= '0;
            frozen_q  <= 1'b0;
            idx_act_q <= 1'b0;
            ev_q      <= 1'b0;
        end else begin
            if (ld_cnt)        cnt_q <= preset;
            else if (zero_cnt) cnt_q <= '0;
            else if (idx_load) cnt_q <= preset;
            else               cnt_q <= cnt_nxt;

            if (host_load || idx_load)
                frozen_q <= 1'b0;
            else if (mode == CM_NORECYCLE && (carry_ev || borrow_ev))
                frozen_q <= 1'b1;

            if (clr_flags) begin
                fl_q.borrow <= 1'b0;
                fl_q.carry  <= 1'b0;
                fl_q.cmp    <= 1'b0;
                fl_q.sign   <= 1'b0;
            end else begin
                fl_q.borrow <= fl_q.borrow ^ borrow_ev;
                fl_q.carry  <= fl_q.carry ^ carry_ev;
                fl_q.cmp    <= fl_q.cmp ^ cmp_ev;
                if (borrow_ev)     fl_q.sign <= 1'b1;
                else if (carry_ev) fl_q.sign <= 1'b0;
            end

            if (clr_err)        fl_q.err <= 1'b0;
            else if (noise_err) fl_q.err <= 1'b1;

            if (step_ok) fl_q.updir <= step_up;

            idx_act_q <= idx_act;
            ev_q      <= ev_sel_hit;
        end
    end

    assign count     = cnt_q;
    assign flags     = fl_q;
    assign event_out = ev_q;

    // R7: front end raises at most one direction strobe per cycle
    assert_one_dir_R7: assert property (@(posedge clk) disable iff (rst)
        !(step_up && step_dn));

    // R7: with counting disabled and no load, the counter holds
    assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        (!ioctl.cnt_en && !host_load && !idx_load) |=> $stable(cnt_q));

    // R8: normal-mode up wrap lands on zero and flips carry
    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_NORMAL && step_ok && step_up && cnt_q == CNT_MAX && !clr_flags)
        |=> (cnt_q == '0 && fl_q.carry != $past(fl_q.carry)));

    // R9: range-limit up step at the ceiling leaves the counter alone
    assert_range_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == CM_RANGE && step_ok && step_up && cnt_q >= preset) |=> $stable(cnt_q));

    // R4: flag clear empties all four event flags
    assert_clr_flags_R4: assert property (@(posedge clk) disable iff (rst)
        clr_flags |=> (!fl_q.borrow && !fl_q.carry && !fl_q.cmp && !fl_q.sign));

    // R14: error flag is sticky until its own clear
    assert_err_sticky_R14: assert property (@(posedge clk) disable iff (rst)
        (fl_q.err && !clr_err) |=> fl_q.err);

endmodule

// File: rtl/poscnt24.sv
module poscnt24
    import poscnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_ctl,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       step_up,
    input  logic       step_dn,
    input  logic       index_in,
    input  logic       noise_err,
    output logic       event_out,
    output logic [7:0] prescale_out
);
    logic [CNT_W-1:0] count, preset;
    flags_t           flags;
    cnt_mode_e        mode;
    ioctl_t           ioctl;
    logic             idx_invert;
    cmd_t             cmd;

    poscnt_host #(.CNT_W(CNT_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_ctl    (bus_ctl),
        .bus_wdata  (bus_wdata),
        .count      (count),
        .flags      (flags),
        .bus_rdata  (bus_rdata),
        .preset     (preset),
        .mode       (mode),
        .ioctl      (ioctl),
        .idx_invert (idx_invert),
        .cmd        (cmd),
        .prescale   (prescale_out)
    );

    poscnt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .ioctl      (ioctl),
        .idx_invert (idx_invert),
        .ld_cnt     (cmd.preset_to_cnt),
        .zero_cnt   (cmd.zero_cnt),
        .clr_flags  (cmd.clr_flags),
        .clr_err    (cmd.clr_err),
        .preset     (preset),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .index_in   (index_in),
        .noise_err  (noise_err),
        .count      (count),
        .flags      (flags),
        .event_out  (event_out)
    );

endmodule

// File: tb/poscnt24_bench.sv
module poscnt24_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd, bus_ctl;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       step_up, step_dn, index_in, noise_err;
    logic       event_out;
    logic [7:0] prescale_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    poscnt24 u_poscnt24 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ctl(bus_ctl),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .step_up(step_up),
        .step_dn(step_dn), .index_in(index_in), .noise_err(noise_err),
        .event_out(event_out), .prescale_out(prescale_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All access tasks start and end on a falling edge.
    task automatic ctl_wr(input logic [7:0] b);
        bus_ctl = 1'b1; bus_wdata = b; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic dat_wr(input logic [7:0] b);
        bus_ctl = 1'b0; bus_wdata = b; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic dat_rd(output logic [7:0] b);
        bus_ctl = 1'b0; bus_rd = 1'b1;
        #1 b = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic stat_rd(output logic [7:0] s);
        bus_ctl = 1'b1; bus_rd = 1'b1;
        #1 s = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic set_preset(input logic [23:0] v);
        ctl_wr(8'h01);
        dat_wr(v[7:0]); dat_wr(v[15:8]); dat_wr(v[23:16]);
    endtask

    task automatic read_count(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        ctl_wr(8'h11);
        dat_rd(b0); dat_rd(b1); dat_rd(b2);
        v = {b2, b1, b0};
    endtask

    task automatic load_count(input logic [23:0] v, input logic [23:0] keep);
        set_preset(v);
        ctl_wr(8'h08);
        set_preset(keep);
    endtask

    task automatic set_mode(input logic [1:0] m);
        ctl_wr(8'h20 | {5'd0, m, 1'b0});
    endtask

    task automatic set_io(input logic [1:0] evs, input logic ldn, input logic en);
        ctl_wr(8'h40 | {3'd0, evs, 1'b0, ldn, en});
    endtask

    task automatic steps(input logic up, input int n, output int ev);
        ev = 0;
        for (int i = 0; i < n; i++) begin
            step_up = up; step_dn = ~up;
            @(negedge clk);
            step_up = 1'b0; step_dn = 1'b0;
            ev += int'(event_out);
        end
    endtask

    task automatic t_reset;
        logic [7:0] s, b;
        stat_rd(s);
        check("R1 status after reset", s, 8'h00);
        for (int i = 0; i < 3; i++) begin
            dat_rd(b);
            check("R1 latch byte after reset", b, 8'h00);
        end
        check("R1 event_out after reset", event_out, 1'b0);
        check("R1 prescale after reset", prescale_out, 8'h00);
    endtask

    task automatic t_transfer;
        logic [23:0] v;
        logic [7:0] b;
        set_preset(24'h123456);
        ctl_wr(8'h08);
        ctl_wr(8'h11);
        dat_rd(b);
        check("R3 first latch byte is LSB", b, 8'h56);
        dat_rd(b); dat_rd(b);
        check("R3 third latch byte is MSB", b, 8'h12);
        read_count(v);
        check("R5 preset to counter", v, 24'h123456);
        dat_wr(8'hAA); dat_wr(8'hBB); dat_wr(8'hCC);
        read_count(v);
        check("R5 data writes leave counter", v, 24'h123456);
        ctl_wr(8'h08);
        read_count(v);
        check("R3 pointer wrapped, bytes LSB first", v, 24'hCCBBAA);
        ctl_wr(8'h18);
        check("R5 preset low byte to prescaler", prescale_out, 8'hAA);
    endtask

    task automatic t_disabled;
        logic [23:0] v;
        int ev;
        steps(1'b1, 4, ev);
        read_count(v);
        check("R7 no counting while disabled", v, 24'hCCBBAA);
        ctl_wr(8'h02);
        read_count(v);
        check("R4 zero counter command", v, 24'h0);
    endtask

    task automatic t_normal;
        logic [23:0] v;
        logic [7:0] s;
        int ev;
        set_io(2'd0, 1'b1, 1'b1);
        set_mode(2'd0);
        load_count(24'hFFFFFE, 24'h000010);
        ctl_wr(8'h04);
        steps(1'b1, 3, ev);
        read_count(v);
        check("R8 up wrap count", v, 24'h000001);
        check("R12 one carry event", ev, 1);
        stat_rd(s);
        check("R6 status after up wrap", s, 8'h22);
        check("R8 borrow xor carry is 25th bit", s[0] ^ s[1], 1'b1);
        ctl_wr(8'h04);
        steps(1'b0, 2, ev);
        read_count(v);
        check("R8 down wrap count", v, 24'hFFFFFF);
        check("R12 carry select ignores borrow", ev, 0);
        stat_rd(s);
        check("R6 status after down wrap", s, 8'h09);
    endtask

    task automatic t_range;
        logic [23:0] v;
        logic [7:0] s;
        int ev;
        set_mode(2'd1);
        load_count(24'd3, 24'd5);
        ctl_wr(8'h04);
        steps(1'b1, 3, ev);
        read_count(v);
        check("R9 clamp at preset", v, 24'd5);
        stat_rd(s);
        check("R9 status at ceiling", s, 8'h26);
        ctl_wr(8'h04);
        steps(1'b0, 6, ev);
        read_count(v);
        check("R9 clamp at zero", v, 24'd0);
        stat_rd(s);
        check("R9 status at floor", s, 8'h09);
    endtask

    task automatic t_modulo;
        logic [23:0] v;
        logic [7:0] s;
        int ev;
        set_mode(2'd3);
        set_io(2'd2, 1'b1, 1'b1);
        load_count(24'd3, 24'd4);
        ctl_wr(8'h04);
        steps(1'b1, 3, ev);
        read_count(v);
        check("R11 up past preset restarts at 0", v, 24'd1);
        check("R12 wrap select sees carry", ev, 1);
        stat_rd(s);
        check("R11 status after up", s, 8'h26);
        ctl_wr(8'h04);
        steps(1'b0, 3, ev);
        read_count(v);
        check("R11 down below 0 reloads preset", v, 24'd3);
        check("R12 wrap select sees borrow", ev, 1);
        stat_rd(s);
        check("R11 status after down", s, 8'h0D);
    endtask

    task automatic t_norecycle;
        logic [23:0] v;
        int ev;
        set_mode(2'd2);
        load_count(24'hFFFFFE, 24'h000100);
        steps(1'b1, 4, ev);
        read_count(v);
        check("R10 frozen after wrap", v, 24'd0);
        check("R10 single wrap event", ev, 1);
        ctl_wr(8'h02);
        steps(1'b1, 2, ev);
        read_count(v);
        check("R10 zero command releases freeze", v, 24'd2);
    endtask

    task automatic t_compare;
        logic [23:0] v;
        logic [7:0] s;
        int ev;
        set_mode(2'd0);
        set_io(2'd1, 1'b1, 1'b1);
        load_count(24'h1E, 24'h20);
        ctl_wr(8'h04);
        steps(1'b1, 3, ev);
        read_count(v);
        check("R12 count passes preset", v, 24'h21);
        check("R12 one compare pulse", ev, 1);
        stat_rd(s);
        check("R12 compare toggle in status", s, 8'h24);
    endtask

    task automatic pulse_index(input logic active, output int ev);
        index_in = active;
        @(negedge clk);
        ev = int'(event_out);
        index_in = ~active;
        @(negedge clk);
    endtask

    task automatic t_index;
        logic [23:0] v;
        int ev;
        set_io(2'd3, 1'b0, 1'b1);
        load_count(24'h10, 24'h77);
        pulse_index(1'b1, ev);
        read_count(v);
        check("R13 index loads preset", v, 24'h77);
        check("R12 index event pulse", ev, 1);
        set_io(2'd3, 1'b1, 1'b1);
        load_count(24'h10, 24'h77);
        pulse_index(1'b1, ev);
        read_count(v);
        check("R13 index load disabled", v, 24'h10);
        index_in = 1'b1;
        @(negedge clk);
        ctl_wr(8'h62);
        set_io(2'd3, 1'b0, 1'b1);
        pulse_index(1'b0, ev);
        read_count(v);
        check("R13 inverted index loads preset", v, 24'h77);
        set_io(2'd0, 1'b1, 1'b1);
        index_in = 1'b0;
        @(negedge clk);
        ctl_wr(8'h60);
    endtask

    task automatic t_error;
        logic [7:0] s;
        noise_err = 1'b1;
        @(negedge clk);
        noise_err = 1'b0;
        repeat (3) @(negedge clk);
        stat_rd(s);
        check("R14 error set and held", s[4], 1'b1);
        ctl_wr(8'h04);
        stat_rd(s);
        check("R14 flag clear keeps error", s[4], 1'b1);
        ctl_wr(8'h06);
        stat_rd(s);
        check("R4 clear error command", s[4], 1'b0);
    endtask

    task automatic t_regsel;
        logic [23:0] v;
        int ev;
        set_mode(2'd0);
        set_io(2'd0, 1'b1, 1'b1);
        load_count(24'h40, 24'h0);
        ctl_wr(8'hFE);
        ctl_wr(8'h80);
        ctl_wr(8'hA4);
        steps(1'b1, 1, ev);
        read_count(v);
        check("R2 unused selects change nothing", v, 24'h41);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        bus_wr = 1'b0; bus_rd = 1'b0; bus_ctl = 1'b0; bus_wdata = 8'h00;
        step_up = 1'b0; step_dn = 1'b0; index_in = 1'b0; noise_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_transfer();
        t_disabled();
        t_normal();
        t_range();
        t_modulo();
        t_norecycle();
        t_compare();
        t_index();
        t_error();
        t_regsel();
        done = 1'b1;
        finish_run();
    end

endmodule